// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block samples the SDRAM control pins on each rising clock edge and decodes them into a command. It then judges whether that command is legal, given the state it keeps for two banks. For each bank it records whether the bank is open, which row the bank holds, and how many cycles remain before a column access may follow that bank's activate. Both banks may be open at the same time, so column commands can be interleaved between two pages.

A small burst tracker records the direction and the remaining length of the current burst. A new column command may cut a running burst on any cycle and start a fresh full-length burst. A write that cuts a read burst is legal only if the data mask is asserted in that cycle. A refresh or mode-set command while any bank is open is flagged as illegal. An illegal command is reported but leaves every piece of state as it was.

The block is intended as the protocol-checking front end of a two-bank SDRAM model controller. The decoded command and the legal flag are registered. They refer to the command sampled at the most recent edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The command sampled at an edge appears on cmd_o after that same edge. With cs_ni high the code is 0 (inhibit). Otherwise the code is set by {ras_ni,cas_ni,we_ni}: 111 gives 1 (no-op), 011 gives 2 (activate), 101 gives 3 (read), 100 gives 4 (write), 001 gives 7 (refresh), 000 gives 8 (mode set) and 110 gives 9 (burst stop). For 010 the code is 5 (precharge of one bank) when addr_i[10] is low, and 6 (precharge of all banks) when addr_i[10] is high. Inhibit, no-op and burst stop are always legal.
- R2: An activate to a closed bank is legal. It opens bank ba_i, so bank_open_o[ba_i] goes to 1, and it stores addr_i in open_row_o[ba_i*11 +: 11]. An activate to a bank that is already open is illegal.
- R3: A read or write to a closed bank is illegal.
- R4: Suppose a bank was activated at edge k. A read or write to that bank at edge k+n is legal only if n >= trcd_i, where trcd_i is the value sampled at the activate.
- R5: Both banks can be open at once. Each bank keeps its own row and its own activate-to-column counter, and column commands may alternate between the two banks.
- R6: A precharge of one bank closes bank ba_i. A precharge of all banks closes both. Both forms are legal whatever the state.
- R7: Refresh and mode set are illegal while any bank is open, and legal when all banks are closed.
- R8: A legal read or write at edge k starts a burst of 2^bl_sel_i beats (bl_sel_i from 0 to 3). The burst stays active for edges k+1 to k+2^bl_sel_i-1. A new legal column command inside that window restarts the burst at full length.
- R9: A write sampled while a read burst is active is illegal if dqm_i is low, and legal if dqm_i is high. A burst stop ends the active burst at once.
- R10: An illegal command changes no bank state, no stored row and no burst state.
- R11: Reset (rst_ni low, asynchronous) closes all banks, clears the stored rows, clears the counters and the burst, sets cmd_o to 0 and sets legal_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; pins sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 1 | Bank address |
| addr_i | input | 11 | Row address on activate; bit 10 selects all banks on precharge |
| dqm_i | input | 1 | Data mask sampled with a write command |
| trcd_i | input | 3 | Activate-to-column delay in cycles |
| bl_sel_i | input | 2 | Burst length select, length 2^bl_sel_i |
| cmd_o | output | 4 | Decoded command code (R1) |
| legal_o | output | 1 | 1 when the last sampled command was legal |
| bank_open_o | output | 2 | Open flag per bank |
| open_row_o | output | 22 | Stored row per bank, bank 0 in the low bits |

## Verification
A bank-state error shows up at the edge where it happens: bank_open_o and open_row_o are registered copies of the state. A wrong activate-to-column counter or burst counter has no dedicated output. It shows only through legal_o on a later column command. The bench therefore places column commands exactly at the boundary cycles: n = trcd_i - 1 and n = trcd_i after an activate, and the last and first cycle of a burst window. This makes an off-by-one visible one cycle after the command that exposes it. A restart that fails to reload the burst shows up as a masked-write rule that is lifted too early.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACT     = 4'd2,
    CMD_RD      = 4'd3,
    CMD_WR      = 4'd4,
    CMD_PRE     = 4'd5,
    CMD_PALL    = 4'd6,
    CMD_REF     = 4'd7,
    CMD_MRS     = 4'd8,
    CMD_BST     = 4'd9
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic all_banks_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_INHIBIT;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = all_banks_i ? CMD_PALL : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int ROW_W  = 11,
  parameter int TRCD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              close_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [TRCD_W-1:0] trcd_i,
  output logic              open_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              ready_o
);
  logic [TRCD_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
      wait_q <= '0;
    end else begin
      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
        // column legal at edge k+n once n >= trcd
        wait_q <= (trcd_i == '0) ? '0 : trcd_i - TRCD_W'(1);
      end else begin
        if (close_i) open_o <= 1'b0;
        if (wait_q != '0) wait_q <= wait_q - TRCD_W'(1);
      end
    end
  end

  assign ready_o = (wait_q == '0);
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
  parameter int BL_SEL_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                start_rd_i,
  input  logic                stop_i,
  input  logic [BL_SEL_W-1:0] bl_sel_i,
  output logic                rd_busy_o
);
  localparam int MAX_LEN = 1 << ((1 << BL_SEL_W) - 1);
  localparam int REM_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  logic [REM_W-1:0] rem_q;
  logic             rd_q;
  logic [REM_W:0]   len;

  assign len = (REM_W+1)'(1) << bl_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      rd_q  <= 1'b0;
    end else if (start_i) begin
      rem_q <= REM_W'(len - (REM_W+1)'(1));
      rd_q  <= start_rd_i;
    end else if (stop_i) begin
      rem_q <= '0;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign rd_busy_o = rd_q && (rem_q != '0);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int AP_BIT    = 10,
  parameter int TRCD_W    = 3,
  parameter int BL_SEL_W  = 2,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  input  logic                       dqm_i,
  input  logic [TRCD_W-1:0]          trcd_i,
  input  logic [BL_SEL_W-1:0]        bl_sel_i,
  output logic [3:0]                 cmd_o,
  output logic                       legal_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
  cmd_e                 dec;
  logic                 legal;
  logic                 rd_busy;
  logic [NUM_BANKS-1:0] open_w, ready_w;
  logic                 sel_open, sel_ready;

  sdram_cmd_decode u_dec (
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .all_banks_i(addr_i[AP_BIT]),
    .cmd_o      (dec)
  );

  assign sel_open  = open_w[ba_i];
  assign sel_ready = ready_w[ba_i];

  always_comb begin
    unique case (dec)
      CMD_ACT:          legal = !sel_open;
      CMD_RD:           legal = sel_open && sel_ready;
      CMD_WR:           legal = sel_open && sel_ready && !(rd_busy && !dqm_i);
      CMD_REF, CMD_MRS: legal = (open_w == '0);
      default:          legal = 1'b1;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, act_b, close_b;
    assign hit     = (ba_i == BA_W'(b));
    assign act_b   = legal && (dec == CMD_ACT) && hit;
    assign close_b = (dec == CMD_PALL) || ((dec == CMD_PRE) && hit);

    sdram_bank_state #(
      .ROW_W (ROW_W),
      .TRCD_W(TRCD_W)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act_b),
      .close_i(close_b),
      .row_i  (addr_i),
      .trcd_i (trcd_i),
      .open_o (open_w[b]),
      .row_o  (open_row_o[b*ROW_W +: ROW_W]),
      .ready_o(ready_w[b])
    );
  end

  sdram_burst_track #(
    .BL_SEL_W(BL_SEL_W)
  ) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (legal && ((dec == CMD_RD) || (dec == CMD_WR))),
    .start_rd_i(dec == CMD_RD),
    .stop_i    (dec == CMD_BST),
    .bl_sel_i  (bl_sel_i),
    .rd_busy_o (rd_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= CMD_INHIBIT;
      legal_o <= 1'b1;
    end else begin
      cmd_o   <= dec;
      legal_o <= legal;
    end
  end

  assign bank_open_o = open_w;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int BA_W      = 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_ni,
  input logic                       ras_ni,
  input logic                       cas_ni,
  input logic                       we_ni,
  input logic [BA_W-1:0]            ba_i,
  input logic                       ap_i,
  input logic [3:0]                 cmd_o,
  input logic                       legal_o,
  input logic [NUM_BANKS-1:0]       bank_open_o,
  input logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
  a_r1_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == 4'd0) && legal_o);

  a_r2_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !ras_ni && cas_ni && we_ni && !bank_open_o[ba_i])
      |=> bank_open_o[$past(ba_i)]);

  a_r3_col_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && ras_ni && !cas_ni && !bank_open_o[ba_i]) |=> !legal_o);

  a_r6_pall_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !ras_ni && cas_ni && !we_ni && ap_i) |=> (bank_open_o == '0));

  a_r7_ref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_o && cmd_o == 4'd7) |-> (bank_open_o == '0));

  a_r10_inhibit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(bank_open_o) && $stable(open_row_o));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .NUM_BANKS(NUM_BANKS),
  .ROW_W    (ROW_W),
  .BA_W     (BA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .ba_i       (ba_i),
  .ap_i       (addr_i[AP_BIT]),
  .cmd_o      (cmd_o),
  .legal_o    (legal_o),
  .bank_open_o(bank_open_o),
  .open_row_o (open_row_o)
);

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic [3:0]  pins;   // cs ras cas we
    logic        ba;
    logic [10:0] addr;
    logic        dqm;
    logic [3:0]  cmd;
    logic        legal;
    logic [1:0]  open;
  } vec_t;

  // trcd_i = 2, bl_sel_i = 2 (four beats)
  localparam vec_t VEC [NV] = '{
    '{4'b0111, 1'b0, 11'h000, 1'b0, 4'd1, 1'b1, 2'b00},  // R1 nop
    '{4'b0011, 1'b0, 11'h005, 1'b0, 4'd2, 1'b1, 2'b01},  // R2 act b0
    '{4'b0101, 1'b0, 11'h000, 1'b0, 4'd3, 1'b0, 2'b01},  // R4 n=1
    '{4'b0101, 1'b0, 11'h000, 1'b0, 4'd3, 1'b1, 2'b01},  // R4 n=2
    '{4'b0100, 1'b0, 11'h000, 1'b0, 4'd4, 1'b0, 2'b01},  // R9 unmasked
    '{4'b0100, 1'b0, 11'h000, 1'b1, 4'd4, 1'b1, 2'b01},  // R9 masked
    '{4'b0101, 1'b0, 11'h000, 1'b0, 4'd3, 1'b1, 2'b01},  // R8 read
    '{4'b0011, 1'b1, 11'h009, 1'b0, 4'd2, 1'b1, 2'b11},  // R5 act b1
    '{4'b0100, 1'b1, 11'h000, 1'b0, 4'd4, 1'b0, 2'b11},  // R4 b1 n=1
    '{4'b0100, 1'b1, 11'h000, 1'b0, 4'd4, 1'b0, 2'b11},  // R9 last beat
    '{4'b0100, 1'b1, 11'h000, 1'b0, 4'd4, 1'b1, 2'b11},  // R8 window over
    '{4'b0001, 1'b0, 11'h000, 1'b0, 4'd7, 1'b0, 2'b11},  // R7 ref open
    '{4'b0011, 1'b0, 11'h00F, 1'b0, 4'd2, 1'b0, 2'b11},  // R2 reopen
    '{4'b0010, 1'b0, 11'h000, 1'b0, 4'd5, 1'b1, 2'b10},  // R6 pre b0
    '{4'b0101, 1'b0, 11'h000, 1'b0, 4'd3, 1'b0, 2'b10},  // R3 closed
    '{4'b0000, 1'b0, 11'h000, 1'b0, 4'd8, 1'b0, 2'b10},  // R7 mrs open
    '{4'b0110, 1'b0, 11'h000, 1'b0, 4'd9, 1'b1, 2'b10},  // R1 bst
    '{4'b0010, 1'b0, 11'h400, 1'b0, 4'd6, 1'b1, 2'b00},  // R6 pall
    '{4'b0001, 1'b0, 11'h000, 1'b0, 4'd7, 1'b1, 2'b00},  // R7 ref idle
    '{4'b0000, 1'b0, 11'h000, 1'b0, 4'd8, 1'b1, 2'b00},  // R7 mrs idle
    '{4'b1000, 1'b0, 11'h000, 1'b0, 4'd0, 1'b1, 2'b00}   // R1 inhibit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        ba = 1'b0;
  logic [10:0] addr = '0;
  logic        dqm = 1'b0;
  logic [2:0]  trcd = 3'd2;
  logic [1:0]  bl_sel = 2'd2;
  logic [3:0]  cmd;
  logic        legal;
  logic [1:0]  bank_open;
  logic [21:0] open_row;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cs_ni      (cs_n),
    .ras_ni     (ras_n),
    .cas_ni     (cas_n),
    .we_ni      (we_n),
    .ba_i       (ba),
    .addr_i     (addr),
    .dqm_i      (dqm),
    .trcd_i     (trcd),
    .bl_sel_i   (bl_sel),
    .cmd_o      (cmd),
    .legal_o    (legal),
    .bank_open_o(bank_open),
    .open_row_o (open_row)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] p, input logic b, input logic [10:0] a, input logic m);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    addr = a;
    dqm = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input int n);
    for (int k = 0; k < n; k++) step(4'b0111, 1'b0, 11'h000, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset cmd", cmd, 0);
    check("R11 reset legal", legal, 1);
    check("R11 reset open", bank_open, 0);
    check("R11 reset rows", open_row, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].pins, VEC[i].ba, VEC[i].addr, VEC[i].dqm);
      check($sformatf("R1 vec %0d cmd", i), cmd, VEC[i].cmd);
      check($sformatf("R10 vec %0d legal", i), legal, VEC[i].legal);
      check($sformatf("R5 vec %0d open", i), bank_open, VEC[i].open);
      if (i == 7) check("R5 bank1 row", open_row[21:11], 11'h009);
      if (i == 12) check("R10 bank0 row kept", open_row[10:0], 11'h005);
    end

    // R8 restart: eight-beat bursts, trcd 0
    bl_sel = 2'd3;
    trcd = 3'd0;
    step(4'b0011, 1'b0, 11'h5A3, 1'b0);
    check("R2 row stored", open_row[10:0], 11'h5A3);
    step(4'b0101, 1'b0, 11'h000, 1'b0);
    check("R4 trcd0 read", legal, 1);
    nop(2);
    step(4'b0101, 1'b0, 11'h000, 1'b0);
    nop(6);
    step(4'b0100, 1'b0, 11'h000, 1'b0);
    check("R8 restarted window", legal, 0);
    step(4'b0100, 1'b0, 11'h000, 1'b0);
    check("R8 window end", legal, 1);

    // R9 burst stop ends read
    step(4'b0101, 1'b0, 11'h000, 1'b0);
    step(4'b0110, 1'b0, 11'h000, 1'b0);
    step(4'b0100, 1'b0, 11'h000, 1'b0);
    check("R9 write after stop", legal, 1);

    // R8 single-beat burst
    bl_sel = 2'd0;
    step(4'b0101, 1'b0, 11'h000, 1'b0);
    step(4'b0100, 1'b0, 11'h000, 1'b0);
    check("R8 bl1 write", legal, 1);

    // R4 boundary with trcd 5
    trcd = 3'd5;
    step(4'b0011, 1'b1, 11'h123, 1'b0);
    check("R5 both open", bank_open, 2'b11);
    trcd = 3'd0;
    nop(3);
    step(4'b0101, 1'b1, 11'h000, 1'b0);
    check("R4 n=4 of 5", legal, 0);
    step(4'b0101, 1'b1, 11'h000, 1'b0);
    check("R4 n=5 of 5", legal, 1);
    step(4'b0101, 1'b0, 11'h000, 1'b0);
    check("R5 interleave b0", legal, 1);

    // R11 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R11 async open", bank_open, 0);
    check("R11 async rows", open_row, 0);
    check("R11 async cmd", cmd, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0101, 1'b0, 11'h000, 1'b0);
    check("R3 read after reset", legal, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule